// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block lays a 64x64 pointer image over the pixel stream on its way to the panel. Each cursor pixel is a 2-bit code held in a 1024-byte cursor store. As the raster passes through the cursor window, the overlay fetches the byte that covers the current pixel and extracts that pixel's code. It then replaces the background pixel with one of two programmable RGB565 colors, inverts it, or lets it through untouched. Outside the window, or while the cursor is switched off, every pixel passes through unchanged. The overlay adds one clock of latency.

The host reaches the block through a byte-wide register write port and a byte-wide cursor-store write port. The cursor position is double-buffered, so it can be written at any moment without tearing the image. A small two-state machine tracks the vertical blanking input: `ST_SCAN` is the visible part of the frame and `ST_BLANK` is vertical non-display. The transition `ST_SCAN -> ST_BLANK`, taken on the first clock that sees `vblank` high, copies the written position into the active position. The transition `ST_BLANK -> ST_SCAN` is taken when `vblank` falls and copies nothing. Both states hold while `vblank` keeps its level. After reset the machine is in `ST_SCAN`.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor is disabled, the active position is (0,0), both colors are 0 and `out_valid` is 0.
- R2: `out_valid` and `pix_out` follow `pix_valid` and `pix_in` by exactly one clock cycle.
- R3: Bit 6 of the control register (address 0) enables the cursor. While that bit is 0, every pixel passes through unchanged, whatever the other control bits are.
- R4: A pixel is inside the cursor when `raster_x - X` lies in 0..63 and `raster_y - Y` lies in 0..63. Any other pixel passes through unchanged.
- R5: The byte read for an inside pixel is at address row*16 + col/4, where row = `raster_y - Y` and col = `raster_x - X`. The cursor store is written at `mem_addr` with `mem_wdata`.
- R6: Within a byte, col mod 4 = 0 takes bits 7:6, 1 takes bits 5:4, 2 takes bits 3:2 and 3 takes bits 1:0.
- R7: Code 2'b00 outputs color 0, 2'b01 outputs color 1, 2'b10 passes the background pixel through and 2'b11 outputs its bitwise inverse.
- R8: Color 0 low and high bytes are at addresses 5 and 6, and color 1 low and high bytes are at addresses 7 and 8. Each write takes effect immediately.
- R9: X is written as a low byte at address 1 and a high byte at address 2 (bits 2:0 give X[10:8]). Y is written the same way at addresses 3 and 4.
- R10: Position writes go to a shadow copy. The active position changes only on the `ST_SCAN -> ST_BLANK` transition and otherwise stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| mem_we | input | 1 | Cursor store write strobe |
| mem_addr | input | 10 | Cursor store byte address |
| mem_wdata | input | 8 | Cursor store write byte |
| vblank | input | 1 | High during vertical non-display |
| pix_valid | input | 1 | Input pixel qualifier |
| raster_x | input | 11 | Column of the input pixel |
| raster_y | input | 11 | Line of the input pixel |
| pix_in | input | 16 | Background pixel, RGB565 |
| out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 16 | Overlaid pixel, RGB565 |

## Verification
A pixel presented before a rising edge produces its result right after that edge, so every pixel check samples one nanosecond after the single edge that follows the falling edge on which the stimulus was driven. Register and cursor-store writes take effect at the edge that captures them. A position write shows up only after a `vblank` pulse, so the bench checks the old position before the pulse and the new one after it. Each check is made only once the edge that should update the result has passed, and before the next stimulus is applied.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    typedef enum logic [1:0] {
        CODE_COLOR0 = 2'b00,
        CODE_COLOR1 = 2'b01,
        CODE_CLEAR  = 2'b10,
        CODE_INVERT = 2'b11
    } cur_code_t;

    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_BLANK = 1'b1
    } xfer_state_t;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_XLO   = 4'd1;
    localparam logic [3:0] RA_XHI   = 4'd2;
    localparam logic [3:0] RA_YLO   = 4'd3;
    localparam logic [3:0] RA_YHI   = 4'd4;
    localparam logic [3:0] RA_C0LO  = 4'd5;
    localparam logic [3:0] RA_C0HI  = 4'd6;
    localparam logic [3:0] RA_C1LO  = 4'd7;
    localparam logic [3:0] RA_C1HI  = 4'd8;

    localparam int EN_BIT = 6;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int POS_W = 11,
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             vblank,
    output logic             cur_en,
    output logic [POS_W-1:0] act_x,
    output logic [POS_W-1:0] act_y,
    output logic [PIX_W-1:0] color0,
    output logic [PIX_W-1:0] color1
);

    localparam int HI_W = POS_W - 8;
    localparam int CHI_W = PIX_W - 8;

    xfer_state_t state, state_nxt;
    logic [POS_W-1:0] shd_x, shd_y;
    logic load_act;

    // host register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_en <= 1'b0;
            shd_x  <= '0;
            shd_y  <= '0;
            color0 <= '0;
            color1 <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL: cur_en             <= reg_wdata[EN_BIT];
                RA_XLO:  shd_x[7:0]         <= reg_wdata;
                RA_XHI:  shd_x[POS_W-1:8]   <= reg_wdata[HI_W-1:0];
                RA_YLO:  shd_y[7:0]         <= reg_wdata;
                RA_YHI:  shd_y[POS_W-1:8]   <= reg_wdata[HI_W-1:0];
                RA_C0LO: color0[7:0]        <= reg_wdata;
                RA_C0HI: color0[PIX_W-1:8]  <= reg_wdata[CHI_W-1:0];
                RA_C1LO: color1[7:0]        <= reg_wdata;
                RA_C1HI: color1[PIX_W-1:8]  <= reg_wdata[CHI_W-1:0];
                default: ;
            endcase
        end
    end

    // transfer state machine: next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SCAN:  if (vblank)  state_nxt = ST_BLANK;
            ST_BLANK: if (!vblank) state_nxt = ST_SCAN;
            default:  state_nxt = ST_SCAN;
        endcase
    end

    // transfer state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SCAN;
        else        state <= state_nxt;
    end

    // transfer state machine: outputs
    always_comb load_act = (state == ST_SCAN) && vblank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_x <= '0;
            act_y <= '0;
        end else if (load_act) begin
            act_x <= shd_x;
            act_y <= shd_y;
        end
    end

    // R10
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_SCAN && vblank) |=> ($stable(act_x) && $stable(act_y)));

    // R10
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && vblank) |=> (act_x == $past(shd_x) && act_y == $past(shd_y)));

endmodule

// File: rtl/cursor_mem.sv
module cursor_mem #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int PIX_W   = 16,
    parameter int CUR_DIM = 64,
    localparam int COORD_W = $clog2(CUR_DIM),
    localparam int ADDR_W  = 2 * COORD_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [POS_W-1:0]  raster_x,
    input  logic [POS_W-1:0]  raster_y,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              cur_en,
    input  logic [POS_W-1:0]  act_x,
    input  logic [POS_W-1:0]  act_y,
    input  logic [PIX_W-1:0]  color0,
    input  logic [PIX_W-1:0]  color1,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              out_valid,
    output logic [PIX_W-1:0]  pix_out
);

    localparam int PIX_PER_BYTE = 4;
    localparam logic [POS_W:0] DIM_L = (POS_W+1)'(CUR_DIM);

    logic [POS_W:0] dx, dy;
    logic in_x, in_y;
    logic hit_q;
    logic [1:0] sel_q;
    logic [PIX_W-1:0] pix_q;
    cur_code_t codes [PIX_PER_BYTE];
    cur_code_t code;

    // window compare: a negative difference wraps to a large value
    always_comb begin
        dx   = {1'b0, raster_x} - {1'b0, act_x};
        dy   = {1'b0, raster_y} - {1'b0, act_y};
        in_x = dx < DIM_L;
        in_y = dy < DIM_L;
        rd_addr = {dy[COORD_W-1:0], dx[COORD_W-1:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hit_q     <= 1'b0;
            sel_q     <= '0;
            pix_q     <= '0;
        end else begin
            out_valid <= pix_valid;
            hit_q     <= cur_en && in_x && in_y;
            sel_q     <= dx[1:0];
            pix_q     <= pix_in;
        end
    end

    // unpack: leftmost pixel in the top bit pair
    for (genvar i = 0; i < PIX_PER_BYTE; i++) begin : g_unpack
        assign codes[i] = cur_code_t'(rd_data[7-2*i -: 2]);
    end

    always_comb begin
        code = codes[sel_q];
        if (!hit_q) begin
            pix_out = pix_q;
        end else begin
            unique case (code)
                CODE_COLOR0: pix_out = color0;
                CODE_COLOR1: pix_out = color1;
                CODE_CLEAR:  pix_out = pix_q;
                CODE_INVERT: pix_out = ~pix_q;
                default:     pix_out = pix_q;
            endcase
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(pix_valid)));

    // R4
    outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_x && in_y) |=> (pix_out == $past(pix_in)));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int PIX_W   = 16,
    parameter int CUR_DIM = 64,
    localparam int COORD_W = $clog2(CUR_DIM),
    localparam int ADDR_W  = 2 * COORD_W - 2,
    localparam int DEPTH   = CUR_DIM * CUR_DIM / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic              vblank,
    input  logic              pix_valid,
    input  logic [POS_W-1:0]  raster_x,
    input  logic [POS_W-1:0]  raster_y,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [PIX_W-1:0]  pix_out
);

    logic             cur_en;
    logic [POS_W-1:0] act_x, act_y;
    logic [PIX_W-1:0] color0, color1;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]       rd_data;

    cursor_regs #(.POS_W(POS_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .vblank(vblank),
        .cur_en(cur_en), .act_x(act_x), .act_y(act_y),
        .color0(color0), .color1(color1)
    );

    cursor_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk),
        .wr_en(mem_we), .wr_addr(mem_addr), .wr_data(mem_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cursor_pixel #(.POS_W(POS_W), .PIX_W(PIX_W), .CUR_DIM(CUR_DIM)) u_pix (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .raster_x(raster_x), .raster_y(raster_y),
        .pix_in(pix_in),
        .cur_en(cur_en), .act_x(act_x), .act_y(act_y),
        .color0(color0), .color1(color1),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    // R3
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |=> (pix_out == $past(pix_in)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && !cur_en && act_x == '0 && act_y == '0));

endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        mem_we = 1'b0;
    logic [9:0]  mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        vblank = 1'b0;
    logic        pix_valid = 1'b0;
    logic [10:0] raster_x = '0;
    logic [10:0] raster_y = '0;
    logic [15:0] pix_in = '0;
    logic        out_valid;
    logic [15:0] pix_out;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [15:0] BG  = 16'h1234;
    localparam logic [15:0] C0  = 16'h001F;
    localparam logic [15:0] C1  = 16'hF800;

    always #10 clk = ~clk;

    cursor_overlay dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .vblank(vblank), .pix_valid(pix_valid),
        .raster_x(raster_x), .raster_y(raster_y), .pix_in(pix_in),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_mem(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic vb_pulse();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk);
        @(negedge clk); vblank = 1'b0;
        @(negedge clk);
    endtask

    // one pixel in, result sampled right after the next rising edge
    task automatic pixel(input string req, input int x, input int y,
                         input logic [15:0] p, input logic [15:0] exp);
        @(negedge clk);
        pix_valid = 1'b1; raster_x = 11'(x); raster_y = 11'(y); pix_in = p;
        @(posedge clk); #1;
        check({req, " valid"}, {15'd0, out_valid}, 16'd1);
        check(req, pix_out, exp);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
        // cursor disabled at position (0,0): pixel there passes
        pixel("R1 disabled after reset", 0, 0, BG, BG);
    endtask

    task automatic t_setup();
        for (int i = 0; i < 1024; i++) wr_mem(10'(i), 8'hAA);
        wr_mem(10'd0, 8'h1B);           // codes 00,01,10,11 left to right
        wr_mem(10'd83, 8'h6A);          // row 5, byte 3: leftmost code 01
        wr_mem(10'd1023, 8'hA8);        // row 63, byte 15: rightmost code 00
        wr_reg(4'd5, 8'h1F); wr_reg(4'd6, 8'h00);   // R8 color 0
        wr_reg(4'd7, 8'h00); wr_reg(4'd8, 8'hF8);   // R8 color 1
        wr_reg(4'd1, 8'd100); wr_reg(4'd2, 8'h00);  // R9 X = 100
        wr_reg(4'd3, 8'd200); wr_reg(4'd4, 8'h00);  // R9 Y = 200
        vb_pulse();
        wr_reg(4'd0, 8'h40);                        // R3 enable
    endtask

    task automatic t_codes();
        pixel("R6 R7 col0 color0", 100, 200, BG, C0);
        pixel("R6 R7 col1 color1 R8", 101, 200, BG, C1);
        pixel("R6 R7 col2 transparent", 102, 200, BG, BG);
        pixel("R6 R7 col3 invert", 103, 200, BG, ~BG);
        pixel("R7 invert other bg", 103, 200, 16'hFFFF, 16'h0000);
    endtask

    task automatic t_window();
        pixel("R4 left of window", 99, 200, BG, BG);
        pixel("R4 above window", 100, 199, BG, BG);
        pixel("R4 R5 last byte corner", 163, 263, BG, C0);
        pixel("R4 right of window", 164, 263, BG, BG);
        pixel("R4 below window", 163, 264, BG, BG);
        pixel("R5 row5 col12 address", 112, 205, BG, C1);
        pixel("R5 R6 row5 col13", 113, 205, BG, BG);
    endtask

    task automatic t_buffer();
        wr_reg(4'd1, 8'h05); wr_reg(4'd2, 8'h01);   // X = 0x105 = 261
        pixel("R10 old X still active", 100, 200, BG, C0);
        pixel("R10 new X not yet active", 261, 200, BG, BG);
        vb_pulse();
        pixel("R9 R10 new X high byte", 261, 200, BG, C0);
        pixel("R10 old X released", 100, 200, BG, BG);
    endtask

    task automatic t_enable();
        wr_reg(4'd0, 8'hBF);
        pixel("R3 bit6 clear passes", 261, 200, BG, BG);
        wr_reg(4'd0, 8'h40);
        pixel("R3 bit6 set overlays", 261, 200, BG, C0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        pix_valid = 1'b0; raster_x = 11'd261; raster_y = 11'd200; pix_in = 16'h0F0F;
        @(posedge clk); #1;
        check("R2 out_valid low follows", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        pix_valid = 1'b1; pix_in = 16'hAAAA; raster_x = 11'd0;
        @(posedge clk); #1;
        check("R2 one cycle data", pix_out, 16'hAAAA);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_setup();
        t_codes();
        t_window();
        t_buffer();
        t_enable();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule